// File: doc/BRIEF.md
# Command Mailbox Register File with Doorbell

This block is the host-visible register set of a command mailbox. A host reaches it through a simple memory-mapped port that carries an address, an access size of 1, 2, 4 or 8 bytes and a little-endian value in the low bytes. The block holds a capability word, a control word whose bit 0 is the doorbell, a 64-bit command register, a 64-bit status register, a background-status register that always reads zero, and a 2048-byte payload window. Each register accepts writes only at certain widths, and everything else is dropped without effect.

When a host write leaves the doorbell set while no command is in progress, the block raises a one-cycle request to an external command engine and shows it the command register. The engine later pulses its done input with a 16-bit return code. The block then stores that code in the status register and clears the doorbell. Reads take two cycles and return the addressed bytes in the low lanes of the read data.

Register offsets: capability 0x00 (32-bit), control 0x04 (32-bit), command 0x08, status 0x10, background status 0x18, payload 0x20 up to 0x81F.

Top module: `mbx_regfile`

## Requirements
- R1: After reset the capability word reads 0x0000000B. Bits 4:0 hold the payload size exponent 11 (2048 bytes), bit 5 (interrupt support) is 0 and bit 6 (background support) is 0. Control, command, status and background status read 0, and eng_req is low.
- R2: A write of any size at an address from 0x20 to 0x81F stores exactly the bytes it covers in the payload, with no filtering, and those bytes read back unchanged.
- R3: Below 0x20, 1-byte and 2-byte writes change no register.
- R4: Below 0x20, a 4-byte write is stored only at 0x00 (capability) or 0x04 (control). A 4-byte write to any other offset is ignored.
- R5: Below 0x20, an 8-byte write is stored only at 0x08 (command). 8-byte writes to 0x00, 0x10 (status) and 0x18 (background status) change nothing, and status changes only on engine completion.
- R6: A read of 1, 2, 4 or 8 bytes at an address aligned to its size returns the addressed bytes, little-endian, in the low bytes of host_rdata with the upper bytes zero. It returns them two cycles after host_rd, with host_rvalid high for that one cycle.
- R7: A 4-byte control write with bit 0 set while idle raises eng_req for exactly one cycle, in the cycle after the write edge. During that cycle eng_cmd equals the command register.
- R8: eng_done while busy writes eng_retcode into status bits 63:48 and clears the doorbell, so control bit 0 reads 0.
- R9: While a command is busy, writes to control are ignored: the control word keeps its value and no new eng_req is raised.
- R10: eng_done while idle changes neither status nor control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW (12) | Byte address |
| host_size | input | 2 | Access size: 0=1B, 1=2B, 2=4B, 3=8B |
| host_wdata | input | 64 | Write value in the low bytes |
| host_rdata | output | 64 | Read value in the low bytes |
| host_rvalid | output | 1 | Read data valid |
| eng_req | output | 1 | One-cycle process request to the engine |
| eng_cmd | output | 64 | Current command register |
| eng_done | input | 1 | Engine completion pulse |
| eng_retcode | input | RC_W (16) | Return code stored on completion |

## Verification
The assertions take for granted that the host never issues a read and a write in the same cycle, and that every address is aligned to its access size. The random stimulus draws an address and then rounds it down to a multiple of the chosen size, and it issues one operation at a time. Random control writes keep the doorbell bit clear, so the random phase never starts a command. Done pulses arrive only from directed steps or while idle, which means completion always follows a real request.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {SZ_1B = 2'd0, SZ_2B = 2'd1, SZ_4B = 2'd2, SZ_8B = 2'd3} acc_sz_e;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_REGS = 2'd1, SRC_PAY = 2'd2} rd_src_e;

  localparam int unsigned OFS_CAP  = 0;
  localparam int unsigned OFS_CTRL = 4;
  localparam int unsigned OFS_CMD  = 8;
  localparam int unsigned OFS_STS  = 16;
  localparam int unsigned OFS_BGS  = 24;
  localparam int unsigned OFS_PAY  = 32;
  localparam int unsigned DB_BIT   = 0;
  localparam int unsigned RC_LSB   = 48;

  function automatic logic [7:0] lane_mask(acc_sz_e sz);
    case (sz)
      SZ_1B:   return 8'h01;
      SZ_2B:   return 8'h03;
      SZ_4B:   return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/mbx_ctrl_regs.sv
module mbx_ctrl_regs
  import mbx_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned PAY_LOG2 = 11,
  parameter int unsigned RC_W     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  acc_sz_e         sz,
  input  logic [63:0]     wdata,
  input  logic            eng_done,
  input  logic [RC_W-1:0] eng_rc,
  output logic [31:0]     cap_q,
  output logic [31:0]     ctrl_q,
  output logic [63:0]     cmd_q,
  output logic [63:0]     sts_q,
  output logic            eng_req,
  output logic            busy
);
  localparam logic [31:0] CAP_INIT = 32'(PAY_LOG2) & 32'h0000_001F;

  logic below, w32, w64, cap_we, ctrl_we, cmd_we, launch, finish;

  always_comb begin
    below   = addr < AW'(OFS_PAY);
    w32     = wr && below && (sz == SZ_4B);
    w64     = wr && below && (sz == SZ_8B);
    cap_we  = w32 && (addr == AW'(OFS_CAP));
    ctrl_we = w32 && (addr == AW'(OFS_CTRL)) && !busy;
    cmd_we  = w64 && (addr == AW'(OFS_CMD));
    launch  = ctrl_we && wdata[DB_BIT];
    finish  = busy && eng_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= CAP_INIT;
      ctrl_q  <= '0;
      cmd_q   <= '0;
      sts_q   <= '0;
      busy    <= 1'b0;
      eng_req <= 1'b0;
    end else begin
      eng_req <= launch;
      if (cap_we)  cap_q  <= wdata[31:0];
      if (cmd_we)  cmd_q  <= wdata;
      if (ctrl_we) ctrl_q <= wdata[31:0];
      if (launch)  busy   <= 1'b1;
      if (finish) begin
        busy                         <= 1'b0;
        ctrl_q[DB_BIT]               <= 1'b0;
        sts_q[RC_LSB +: RC_W]        <= eng_rc;
      end
    end
  end

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    eng_req |=> !eng_req);
  assert_req_doorbell_R7: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> (ctrl_q[DB_BIT] && busy));
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done) |=> (!busy && !ctrl_q[DB_BIT]));
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> (busy && $stable(ctrl_q)));
  assert_sts_readonly_R5: assert property (@(posedge clk) disable iff (rst)
    !(busy && eng_done) |=> $stable(sts_q));
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && eng_done && !wr) |=> $stable(ctrl_q));
endmodule

// File: rtl/mbx_payload_ram.sv
module mbx_payload_ram #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       be,
  input  logic [63:0]      wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [63:0]      rdata_q
);
  localparam int unsigned WORDS = 1 << IDX_W;

  logic [63:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (we && be[i]) mem[widx][i*8 +: 8] <= wdata[i*8 +: 8];
    end
    if (re) rdata_q <= mem[ridx];
  end
endmodule

// File: rtl/mbx_rd_path.sv
module mbx_rd_path
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd,
  input  rd_src_e     src,
  input  logic [2:0]  lane,
  input  acc_sz_e     sz,
  input  logic [63:0] reg_word,
  input  logic [63:0] ram_q,
  output logic [63:0] rdata,
  output logic        rvalid
);
  logic        v1;
  rd_src_e     src1;
  logic [2:0]  lane1;
  acc_sz_e     sz1;
  logic [63:0] regw1, pick, shifted, fmt;
  logic [7:0]  keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      src1   <= SRC_NONE;
      lane1  <= '0;
      sz1    <= SZ_1B;
      regw1  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      v1     <= rd;
      rvalid <= v1;
      if (rd) begin
        src1  <= src;
        lane1 <= lane;
        sz1   <= sz;
        regw1 <= reg_word;
      end
      if (v1) rdata <= fmt;
    end
  end

  always_comb begin
    case (src1)
      SRC_PAY:  pick = ram_q;
      SRC_REGS: pick = regw1;
      default:  pick = '0;
    endcase
    shifted = pick >> {lane1, 3'b000};
    keep    = lane_mask(sz1);
    for (int i = 0; i < 8; i++) fmt[i*8 +: 8] = keep[i] ? shifted[i*8 +: 8] : 8'h00;
  end

  assert_rvalid_timing_R6: assert property (@(posedge clk) disable iff (rst)
    rd |-> ##2 rvalid);
  assert_rvalid_single_R6: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !$past(rd)) |=> !rvalid);
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned PAY_LOG2 = 11,
  parameter int unsigned RC_W     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [AW-1:0]   host_addr,
  input  logic [1:0]      host_size,
  input  logic [63:0]     host_wdata,
  output logic [63:0]     host_rdata,
  output logic            host_rvalid,
  output logic            eng_req,
  output logic [63:0]     eng_cmd,
  input  logic            eng_done,
  input  logic [RC_W-1:0] eng_retcode
);
  localparam int unsigned PAY_BYTES = 1 << PAY_LOG2;
  localparam int unsigned IDX_W     = PAY_LOG2 - 3;
  localparam int unsigned PAY_END   = OFS_PAY + PAY_BYTES;

  acc_sz_e        sz;
  logic [AW-1:0]  pofs;
  logic           in_pay, below;
  logic [7:0]     be;
  logic [63:0]    ram_wd, ram_q, reg_word, cmd_q, sts_q;
  logic [31:0]    cap_q, ctrl_q;
  logic           busy;
  rd_src_e        src;

  always_comb begin
    sz     = acc_sz_e'(host_size);
    pofs   = host_addr - AW'(OFS_PAY);
    below  = host_addr < AW'(OFS_PAY);
    in_pay = !below && ({1'b0, host_addr} < (AW+1)'(PAY_END));
    be     = lane_mask(sz) << host_addr[2:0];
    ram_wd = host_wdata << {host_addr[2:0], 3'b000};
    case (host_addr[4:3])
      2'd0:    reg_word = {ctrl_q, cap_q};
      2'd1:    reg_word = cmd_q;
      2'd2:    reg_word = sts_q;
      default: reg_word = '0;
    endcase
    if (in_pay)     src = SRC_PAY;
    else if (below) src = SRC_REGS;
    else            src = SRC_NONE;
  end

  assign eng_cmd = cmd_q;

  mbx_ctrl_regs #(.AW(AW), .PAY_LOG2(PAY_LOG2), .RC_W(RC_W)) u_regs (
    .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr), .sz(sz),
    .wdata(host_wdata), .eng_done(eng_done), .eng_rc(eng_retcode),
    .cap_q(cap_q), .ctrl_q(ctrl_q), .cmd_q(cmd_q), .sts_q(sts_q),
    .eng_req(eng_req), .busy(busy)
  );

  mbx_payload_ram #(.IDX_W(IDX_W)) u_pay (
    .clk(clk), .we(host_wr && in_pay), .widx(pofs[PAY_LOG2-1:3]), .be(be),
    .wdata(ram_wd), .re(host_rd && in_pay), .ridx(pofs[PAY_LOG2-1:3]),
    .rdata_q(ram_q)
  );

  mbx_rd_path u_rd (
    .clk(clk), .rst(rst), .rd(host_rd), .src(src), .lane(host_addr[2:0]),
    .sz(sz), .reg_word(reg_word), .ram_q(ram_q),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );

  assert_one_op_R6: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_rd));
  assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (host_wr || host_rd) |-> ((host_addr[2:0] & 3'((4'd1 << host_size) - 4'd1)) == 3'd0));
  assert_cmd_during_req_R7: assert property (@(posedge clk) disable iff (rst)
    (eng_req && busy) |=> $stable(eng_cmd) || !busy || $past(host_wr));
endmodule

// File: tb/sim_mbx_regfile.sv
module sim_mbx_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        host_rvalid, eng_req;
  logic [63:0] eng_cmd;
  logic        eng_done = 1'b0;
  logic [15:0] eng_retcode = '0;

  int n_chk = 0, n_err = 0;
  logic [31:0] cap_m, ctrl_m;
  logic [63:0] cmd_m, sts_m;
  logic        busy_m;
  logic [7:0]  pay_m [0:2047];

  always #4 clk = ~clk;

  mbx_regfile u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int a);
    logic [63:0] img;
    if (a >= 32 + 2048) return 8'h00;
    if (a >= 32) return pay_m[a - 32];
    case (a / 8)
      0: img = {ctrl_m, cap_m};
      1: img = cmd_m;
      2: img = sts_m;
      default: img = '0;
    endcase
    return img[(a % 8) * 8 +: 8];
  endfunction

  function automatic logic [63:0] exp_read(input int a, input int sz);
    logic [63:0] r = '0;
    for (int k = 0; k < (1 << sz); k++) r |= 64'(byte_at(a + k)) << (8 * k);
    return r;
  endfunction

  task automatic wr(input string tag, input int a, input int sz, input logic [63:0] d);
    logic launch = 1'b0;
    @(negedge clk);
    host_wr = 1'b1; host_addr = 12'(a); host_size = 2'(sz); host_wdata = d;
    if (a >= 32) begin
      for (int k = 0; k < (1 << sz); k++) pay_m[a - 32 + k] = d[8*k +: 8];
    end else if (sz == 2) begin
      if (a == 0) cap_m = d[31:0];
      else if (a == 4 && !busy_m) begin
        ctrl_m = d[31:0];
        if (d[0]) begin busy_m = 1'b1; launch = 1'b1; end
      end
    end else if (sz == 3 && a == 8) cmd_m = d;
    @(negedge clk);
    host_wr = 1'b0;
    check({tag, " R7/R9 eng_req"}, 64'(eng_req), 64'(launch));
    if (launch) check("R7 eng_cmd", eng_cmd, cmd_m);
  endtask

  task automatic rd(input string tag, input int a, input int sz);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 12'(a); host_size = 2'(sz);
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    check({tag, " R6 rvalid"}, 64'(host_rvalid), 64'd1);
    check(tag, host_rdata, exp_read(a, sz));
  endtask

  task automatic done(input logic [15:0] code);
    @(negedge clk);
    eng_done = 1'b1; eng_retcode = code;
    if (busy_m) begin
      busy_m = 1'b0; ctrl_m[0] = 1'b0; sts_m[63:48] = code;
    end
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cap_m = 32'h0000_000B; ctrl_m = '0; cmd_m = '0; sts_m = '0; busy_m = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 eng_req", 64'(eng_req), 64'd0);
    rd("R1 cap", 0, 2);
    check("R1 cap literal", host_rdata, 64'h0000_000B);
    rd("R1 ctrl", 4, 2);
    rd("R1 cmd", 8, 3);
    rd("R1 sts", 16, 3);
    rd("R1 bgs", 24, 3);
    // R2 fill payload with 8-byte writes, then byte-level writes
    for (int w = 0; w < 256; w++) wr("R2 fill", 32 + 8*w, 3, {$urandom, $urandom});
    rd("R2 word0", 32, 3);
    rd("R2 last", 32 + 2040, 3);
    wr("R2 b", 32 + 13, 0, 64'hFFFF_FFFF_FFFF_FFA5);
    rd("R2 b read", 32 + 8, 3);
    wr("R2 h", 32 + 18, 1, 64'h1234_BEEF);
    rd("R2 h read", 32 + 16, 3);
    // R3 narrow writes below payload
    wr("R3 b cmd", 8, 0, 64'h77);
    wr("R3 h ctrl", 4, 1, 64'h1);
    rd("R3 cmd", 8, 3);
    rd("R3 ctrl", 4, 2);
    // R4 4-byte filtering
    wr("R4 cmd lo", 8, 2, 64'hDEAD_BEEF);
    wr("R4 sts", 16, 2, 64'hCAFE_F00D);
    rd("R4 cmd", 8, 3);
    rd("R4 sts", 16, 3);
    wr("R4 cap", 0, 2, 64'h0000_0055);
    rd("R4 cap", 0, 2);
    wr("R4 cap restore", 0, 2, 64'h0000_000B);
    wr("R4 ctrl", 4, 2, 64'hA5A5_0000);
    rd("R4 ctrl", 4, 2);
    // R5 8-byte filtering
    wr("R5 sts", 16, 3, 64'h1111_2222_3333_4444);
    wr("R5 bgs", 24, 3, 64'h5555_6666_7777_8888);
    wr("R5 word0", 0, 3, 64'h9999_AAAA_BBBB_CCCC);
    wr("R5 cmd", 8, 3, 64'h0123_4567_89AB_CDEF);
    rd("R5 sts", 16, 3);
    rd("R5 bgs", 24, 3);
    rd("R5 word0", 0, 3);
    rd("R5 cmd", 8, 3);
    // R6 sub-word reads
    rd("R6 b", 9, 0);
    rd("R6 h", 14, 1);
    rd("R6 w", 12, 2);
    // R7 doorbell launch
    wr("R7 ring", 4, 2, 64'h0000_0001);
    // R9 control writes ignored while busy
    wr("R9 ctrl", 4, 2, 64'h0000_0005);
    rd("R9 ctrl", 4, 2);
    check("R9 ctrl literal", host_rdata, 64'h1);
    // R8 completion
    done(16'hBEEF);
    rd("R8 sts", 16, 3);
    check("R8 sts literal", host_rdata, 64'hBEEF_0000_0000_0000);
    rd("R8 ctrl", 4, 2);
    // R10 done while idle
    done(16'h1234);
    rd("R10 sts", 16, 3);
    rd("R10 ctrl", 4, 2);
    // R7 relaunch after completion
    wr("R7 relaunch", 4, 2, 64'h0000_0003);
    done(16'h00C1);
    rd("R8 sts2", 16, 3);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int sz, a, sel;
      logic [63:0] d;
      sz  = int'($urandom % 4);
      sel = int'($urandom % 10);
      if (sel < 5) a = 32 + (int'($urandom % 2048) & ~((1 << sz) - 1));
      else         a = int'($urandom % 32) & ~((1 << sz) - 1);
      d = {$urandom, $urandom};
      if (a == 4) d[0] = 1'b0;
      case (int'($urandom % 5))
        0, 1: wr("R2/R3/R4/R5 rand", a, sz, d);
        2, 3: rd("R6 rand", a, sz);
        default: done(16'($urandom));
      endcase
    end
    rd("R10 final sts", 16, 3);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule